// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer

This block is a fully associative translation cache for a 64-bit virtual address space with a 4 KB base page. Every entry carries its own page size, which can be any power of two from 4 KB to 4 GB. A lookup compares the virtual address against all entries at once. Each entry compares only the address bits above its own page size. An entry also carries an 8-bit address space identifier (ASID), unless it is marked global, in which case any ASID matches it. When several entries match, the entry with the smallest page wins. This lets a small mapping sit inside a larger one.

A lookup is combinational. In the same cycle it returns a hit flag, the physical address, and fault flags for a non-resident page and for an access the rights do not allow. It also returns the status bits of the matched entry. At the next clock edge the matched entry records that it was used. If the access was a permitted write to a resident page, the entry also records that it is dirty. A write port loads one entry by index. Two flush inputs remove entries: one removes every entry, the other removes the non-global entries of a single ASID. Choosing which entry to replace and filling entries on a miss are left to the surrounding logic.

Top module: `vsp_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses and all lookup outputs are zero.
- R2: A write with `wr_en` high loads the entry at `wr_idx` at the clock edge, with its used and dirty bits cleared. When a write and a flush occur in the same cycle, the written entry is valid afterwards.
- R3: An entry matches when it is valid and its stored page number equals bits 63:12 of the lookup address, ignoring the low `size` bits of the page number. The stored ASID must also equal `lk_asid`, unless the entry is global. The size code means a page of 4 KB shifted left by `size`, so 0 is 4 KB and 20 is 4 GB. A written code above 20 is stored as 20.
- R4: On a permitted hit, the physical address takes its bits above the page size from the stored physical page number and its bits below the page size, including offset bits 11:0, from the lookup address. When there is no permitted hit, `lk_pa` is zero.
- R5: When several entries match, the one with the smallest size code supplies the result. On equal sizes, the lowest index wins.
- R6: A match on an entry whose present bit is clear raises `lk_np_fault` and does not raise `lk_perm_fault`.
- R7: The rights field is 3 bits, bit 2 read, bit 1 write, bit 0 execute. The supervisor field applies when `lk_user` is 0 and the user field when it is 1. The access code `lk_acc` is 0 for read, 1 for write, 2 for execute, and 3 is treated as read. A match on a present entry whose selected right is clear raises `lk_perm_fault`.
- R8: Every hit, faulting or not, sets the used bit of the selected entry at the next edge. `lk_used` shows this bit for the matched entry.
- R9: A write access that hits a present entry without a permission fault sets that entry's dirty bit at the next edge. A faulting write leaves it unchanged. `lk_dirty` shows this bit for the matched entry.
- R10: `flush_all` invalidates every entry at the next edge.
- R11: `flush_asid_en` invalidates exactly the non-global entries whose ASID equals `flush_asid`.
- R12: With `lk_valid` low, the lookup reports no hit and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | IDX_W | Index of the entry to load |
| wr_vpn | input | 52 | Virtual page number |
| wr_ppn | input | 52 | Physical page number |
| wr_asid | input | 8 | Address space identifier |
| wr_global | input | 1 | Entry matches every ASID |
| wr_sup_rwx | input | 3 | Supervisor rights (R,W,X) |
| wr_usr_rwx | input | 3 | User rights (R,W,X) |
| wr_present | input | 1 | Page is resident |
| wr_size | input | 5 | Page size code |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate non-global entries of one ASID |
| flush_asid | input | 8 | ASID for the selective flush |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 64 | Virtual address |
| lk_asid | input | 8 | Current ASID |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor |
| lk_acc | input | 2 | Access type code |
| lk_hit | output | 1 | An entry matched |
| lk_pa | output | 64 | Physical address |
| lk_perm_fault | output | 1 | Access not allowed |
| lk_np_fault | output | 1 | Matched page not resident |
| lk_used | output | 1 | Used bit of the matched entry |
| lk_dirty | output | 1 | Dirty bit of the matched entry |

## Verification
The assertions check the following on every cycle:
- the two faults never occur together;
- a permitted hit keeps the 4 KB offset bits;
- a hit always leaves its entry marked used;
- a permitted write always leaves its entry marked dirty;
- a full flush leaves no valid entry;
- an idle cycle leaves all status bits unchanged;
- the selected index always points at a matching entry.

Only the bench scenarios show the parts that need known contents:
- the smallest-page priority and the tie between equal sizes;
- the address split for each page size, including a clamped size code;
- the ASID and global rules;
- the fact that a selective flush spares global entries and other ASIDs.

// File: rtl/vsp_tlb_pkg.sv
package vsp_tlb_pkg;

  localparam int unsigned VA_W       = 64;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned VPN_W      = VA_W - PAGE_SHIFT;
  localparam int unsigned ASID_W     = 8;
  localparam int unsigned RWX_W      = 3;
  localparam int unsigned SIZE_W     = 5;
  localparam int unsigned MAX_SIZE   = 20;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic              valid;
    logic              present;
    logic              dirty;
    logic              used;
    logic              global_pg;
    logic [ASID_W-1:0] asid;
    logic [RWX_W-1:0]  sup_rwx;
    logic [RWX_W-1:0]  usr_rwx;
    logic [SIZE_W-1:0] size;
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
  } tlb_entry_t;

  // Page-number mask: ones above the page size, zeros below it.
  function automatic logic [VPN_W-1:0] pg_mask(input logic [SIZE_W-1:0] sz);
    pg_mask = {VPN_W{1'b1}} << sz;
  endfunction

  function automatic logic [SIZE_W-1:0] clamp_size(input logic [SIZE_W-1:0] sz);
    clamp_size = (sz > SIZE_W'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE) : sz;
  endfunction

endpackage

// File: rtl/vsp_tlb_match.sv
module vsp_tlb_match
  import vsp_tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16
) (
  input  logic [N_ENTRIES-1:0] ent_valid,
  input  logic [N_ENTRIES-1:0] ent_global,
  input  logic [VPN_W-1:0]     ent_vpn  [N_ENTRIES],
  input  logic [ASID_W-1:0]    ent_asid [N_ENTRIES],
  input  logic [SIZE_W-1:0]    ent_size [N_ENTRIES],
  input  logic [VPN_W-1:0]     lk_vpn,
  input  logic [ASID_W-1:0]    lk_asid,
  output logic [N_ENTRIES-1:0] match_vec
);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic addr_eq;
    logic asid_eq;
    always_comb begin
      addr_eq      = ((ent_vpn[g] ^ lk_vpn) & pg_mask(ent_size[g])) == '0;
      asid_eq      = ent_global[g] || ((ent_asid[g] ^ lk_asid) == '0);
      match_vec[g] = ent_valid[g] && addr_eq && asid_eq;
    end
  end

endmodule

// File: rtl/vsp_tlb_select.sv
module vsp_tlb_select
  import vsp_tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ENTRIES-1:0] match_vec,
  input  logic [SIZE_W-1:0] ent_size [N_ENTRIES],
  output logic              any_match,
  output logic [IDX_W-1:0]  sel_idx
);

  logic [SIZE_W:0] best_sz;

  // Strict less-than keeps the lowest index on equal sizes.
  always_comb begin
    best_sz   = (SIZE_W+1)'(MAX_SIZE + 1);
    sel_idx   = '0;
    any_match = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (match_vec[i] && ({1'b0, ent_size[i]} < best_sz)) begin
        best_sz   = {1'b0, ent_size[i]};
        sel_idx   = IDX_W'(i);
        any_match = 1'b1;
      end
    end
  end

  // R5: the chosen index always names a matching entry
  p_sel_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_match |-> match_vec[sel_idx]);

endmodule

// File: rtl/vsp_tlb.sv
module vsp_tlb
  import vsp_tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_ppn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [RWX_W-1:0]  wr_sup_rwx,
  input  logic [RWX_W-1:0]  wr_usr_rwx,
  input  logic              wr_present,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_user,
  input  logic [1:0]        lk_acc,
  output logic              lk_hit,
  output logic [VA_W-1:0]   lk_pa,
  output logic              lk_perm_fault,
  output logic              lk_np_fault,
  output logic              lk_used,
  output logic              lk_dirty
);

  tlb_entry_t ent_q [N_ENTRIES];
  tlb_entry_t ent_d [N_ENTRIES];
  logic [N_ENTRIES-1:0] ent_we;

  logic [N_ENTRIES-1:0] valid_vec, global_vec, used_vec, dirty_vec;
  logic [VPN_W-1:0]     vpn_arr  [N_ENTRIES];
  logic [ASID_W-1:0]    asid_arr [N_ENTRIES];
  logic [SIZE_W-1:0]    size_arr [N_ENTRIES];

  always_comb begin
    for (int i = 0; i < N_ENTRIES; i++) begin
      valid_vec[i]  = ent_q[i].valid;
      global_vec[i] = ent_q[i].global_pg;
      used_vec[i]   = ent_q[i].used;
      dirty_vec[i]  = ent_q[i].dirty;
      vpn_arr[i]    = ent_q[i].vpn;
      asid_arr[i]   = ent_q[i].asid;
      size_arr[i]   = ent_q[i].size;
    end
  end

  // ---------------- lookup ----------------
  logic [VPN_W-1:0]     lk_vpn;
  logic [N_ENTRIES-1:0] match_vec;
  logic                 any_match;
  logic [IDX_W-1:0]     sel_idx;

  assign lk_vpn = lk_va[VA_W-1:PAGE_SHIFT];

  vsp_tlb_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .ent_valid (valid_vec),
    .ent_global(global_vec),
    .ent_vpn   (vpn_arr),
    .ent_asid  (asid_arr),
    .ent_size  (size_arr),
    .lk_vpn    (lk_vpn),
    .lk_asid   (lk_asid),
    .match_vec (match_vec)
  );

  vsp_tlb_select #(.N_ENTRIES(N_ENTRIES)) u_select (
    .clk      (clk),
    .rst_n    (rst_n),
    .match_vec(match_vec),
    .ent_size (size_arr),
    .any_match(any_match),
    .sel_idx  (sel_idx)
  );

  tlb_entry_t           sel_ent;
  logic [RWX_W-1:0]     rights;
  logic                 allowed;
  logic                 grant;
  logic [VPN_W-1:0]     sel_mask;
  logic [N_ENTRIES-1:0] sel_oh;
  acc_e                 acc;

  always_comb begin
    acc     = acc_e'(lk_acc);
    sel_ent = ent_q[sel_idx];
    rights  = lk_user ? sel_ent.usr_rwx : sel_ent.sup_rwx;
    unique case (acc)
      ACC_WRITE: allowed = rights[1];
      ACC_EXEC:  allowed = rights[0];
      default:   allowed = rights[2];
    endcase
    lk_hit        = lk_valid && any_match;
    lk_np_fault   = lk_hit && !sel_ent.present;
    lk_perm_fault = lk_hit && sel_ent.present && !allowed;
    grant         = lk_hit && sel_ent.present && allowed;
    sel_mask      = pg_mask(sel_ent.size);
    lk_pa         = grant ? {(sel_ent.ppn & sel_mask) | (lk_vpn & ~sel_mask),
                             lk_va[PAGE_SHIFT-1:0]} : '0;
    lk_used       = lk_hit && sel_ent.used;
    lk_dirty      = lk_hit && sel_ent.dirty;
    sel_oh        = lk_hit ? (N_ENTRIES'(1) << sel_idx) : '0;
  end

  // ---------------- entry update ----------------
  tlb_entry_t wr_ent;

  always_comb begin
    wr_ent           = '0;
    wr_ent.valid     = 1'b1;
    wr_ent.present   = wr_present;
    wr_ent.global_pg = wr_global;
    wr_ent.asid      = wr_asid;
    wr_ent.sup_rwx   = wr_sup_rwx;
    wr_ent.usr_rwx   = wr_usr_rwx;
    wr_ent.size      = clamp_size(wr_size);
    wr_ent.vpn       = wr_vpn;
    wr_ent.ppn       = wr_ppn;
  end

  always_comb begin
    for (int i = 0; i < N_ENTRIES; i++) begin
      ent_d[i] = ent_q[i];
      if (sel_oh[i]) begin
        ent_d[i].used = 1'b1;
        if (grant && (acc == ACC_WRITE)) ent_d[i].dirty = 1'b1;
      end
      if (flush_all) ent_d[i].valid = 1'b0;
      if (flush_asid_en && !ent_q[i].global_pg && (ent_q[i].asid == flush_asid))
        ent_d[i].valid = 1'b0;
      if (wr_en && (wr_idx == IDX_W'(i))) ent_d[i] = wr_ent;
      ent_we[i] = sel_oh[i] || flush_all || flush_asid_en ||
                  (wr_en && (wr_idx == IDX_W'(i)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENTRIES; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (ent_we[i]) ent_q[i] <= ent_d[i];
      end
    end
  end

  // ---------------- assertions ----------------
  logic quiet;
  assign quiet = !wr_en && !flush_all && !flush_asid_en;

  p_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_np_fault && lk_perm_fault));

  p_pa_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !lk_np_fault && !lk_perm_fault) |->
      (lk_pa[PAGE_SHIFT-1:0] == lk_va[PAGE_SHIFT-1:0]));

  p_used_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && quiet) |=> ((used_vec & $past(sel_oh)) != '0));

  p_dirty_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !lk_np_fault && !lk_perm_fault && (lk_acc == 2'd1) && quiet)
      |=> ((dirty_vec & $past(sel_oh)) != '0));

  p_flush_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !wr_en) |=> (valid_vec == '0));

  p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_valid && quiet) |=>
      ($stable(valid_vec) && $stable(used_vec) && $stable(dirty_vec)));

endmodule

// File: tb/vsp_tlb_bench.sv
module vsp_tlb_bench;
  import vsp_tlb_pkg::*;

  localparam int unsigned N = 16;
  localparam int unsigned IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_global, wr_present;
  logic [IW-1:0] wr_idx;
  logic [VPN_W-1:0] wr_vpn, wr_ppn;
  logic [7:0] wr_asid, flush_asid, lk_asid;
  logic [2:0] wr_sup_rwx, wr_usr_rwx;
  logic [4:0] wr_size;
  logic flush_all, flush_asid_en, lk_valid, lk_user;
  logic [63:0] lk_va, lk_pa;
  logic [1:0] lk_acc;
  logic lk_hit, lk_perm_fault, lk_np_fault, lk_used, lk_dirty;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vsp_tlb #(.N_ENTRIES(N)) u_vsp_tlb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
    .wr_asid(wr_asid), .wr_global(wr_global), .wr_sup_rwx(wr_sup_rwx),
    .wr_usr_rwx(wr_usr_rwx), .wr_present(wr_present), .wr_size(wr_size),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid), .lk_user(lk_user),
    .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_pa(lk_pa),
    .lk_perm_fault(lk_perm_fault), .lk_np_fault(lk_np_fault),
    .lk_used(lk_used), .lk_dirty(lk_dirty)
  );

  typedef struct packed {
    logic [63:0] va;
    logic [7:0]  asid;
    logic        user;
    logic [1:0]  acc;
    logic        hit;
    logic        perm;
    logic        np;
    logic [63:0] pa;
  } vec_t;

  // Covers R3 (ASID, global, clamp), R4, R5, R6, R7.
  localparam vec_t VECS [12] = '{
    '{64'h0000_0000_0001_0234, 8'd5, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_00AB_C234},
    '{64'h0000_0000_0002_0456, 8'd5, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 64'h0000_0000_1232_0456},
    '{64'h0000_0000_0001_0234, 8'd6, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 64'h0},
    '{64'hFFFF_FFFF_1234_5678, 8'd9, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 64'h0000_0001_1234_5678},
    '{64'hFFFF_FFFF_1234_5678, 8'd9, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 64'h0},
    '{64'hFFFF_FFFF_1234_5678, 8'd9, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 64'h0},
    '{64'h0000_0000_0040_0123, 8'd5, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 64'h0},
    '{64'h0000_0002_ABCD_E123, 8'd7, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 64'h0000_0003_ABCD_E123},
    '{64'h0000_0002_ABCD_E123, 8'd5, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 64'h0},
    '{64'h0000_0000_0001_0FFF, 8'd5, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 64'h0},
    '{64'h0000_0000_0001_0000, 8'd5, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 64'h0000_0000_00AB_C000},
    '{64'h0000_0000_0010_0000, 8'd5, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 64'h0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [VPN_W-1:0] vpn, input logic [VPN_W-1:0] ppn,
                    input logic [7:0] asid, input logic glb, input logic [2:0] sup,
                    input logic [2:0] usr, input logic pres, input logic [4:0] sz);
    @(negedge clk);
    lk_valid = 1'b0;
    wr_en = 1'b1; wr_idx = IW'(idx); wr_vpn = vpn; wr_ppn = ppn; wr_asid = asid;
    wr_global = glb; wr_sup_rwx = sup; wr_usr_rwx = usr; wr_present = pres; wr_size = sz;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [63:0] va, input logic [7:0] asid, input logic user,
                      input logic [1:0] acc, input logic en);
    @(negedge clk);
    wr_en = 1'b0; flush_all = 1'b0; flush_asid_en = 1'b0;
    lk_valid = en; lk_va = va; lk_asid = asid; lk_user = user; lk_acc = acc;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 0; wr_idx = '0; wr_vpn = '0; wr_ppn = '0; wr_asid = '0; wr_global = 0;
    wr_sup_rwx = '0; wr_usr_rwx = '0; wr_present = 0; wr_size = '0;
    flush_all = 0; flush_asid_en = 0; flush_asid = '0;
    lk_valid = 0; lk_va = '0; lk_asid = '0; lk_user = 0; lk_acc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset
    look(64'h0000_0000_0001_0234, 8'd5, 1'b0, 2'd0, 1'b1);
    chk("R1 hit", 64'(lk_hit), 64'd0);
    chk("R1 pa", lk_pa, 64'd0);
    chk("R1 faults", 64'({lk_perm_fault, lk_np_fault, lk_used, lk_dirty}), 64'd0);

    // Load entries (R2)
    wr(0, 52'h10,          52'hABC,    8'd5, 1'b0, 3'd7, 3'd5, 1'b1, 5'd0);
    wr(1, 52'h0,           52'h12300,  8'd5, 1'b0, 3'd7, 3'd7, 1'b1, 5'd8);
    wr(2, 52'hFFFFFFFF00000, 52'h100000, 8'd1, 1'b1, 3'd6, 3'd0, 1'b1, 5'd20);
    wr(3, 52'h400,         52'h999,    8'd5, 1'b0, 3'd7, 3'd7, 1'b0, 5'd0);
    wr(4, 52'h200000,      52'h300000, 8'd7, 1'b0, 3'd7, 3'd4, 1'b1, 5'd31);
    wr(5, 52'h10,          52'hDEF,    8'd5, 1'b0, 3'd7, 3'd7, 1'b1, 5'd0);

    foreach (VECS[k]) begin
      look(VECS[k].va, VECS[k].asid, VECS[k].user, VECS[k].acc, 1'b1);
      chk($sformatf("R3 R5 table %0d hit", k), 64'(lk_hit), 64'(VECS[k].hit));
      chk($sformatf("R4 table %0d pa", k), lk_pa, VECS[k].pa);
      chk($sformatf("R7 table %0d perm", k), 64'(lk_perm_fault), 64'(VECS[k].perm));
      chk($sformatf("R6 table %0d np", k), 64'(lk_np_fault), 64'(VECS[k].np));
    end

    // R9: permitted write on entry 1 marked dirty; R8 used
    look(64'h0000_0000_0002_0000, 8'd5, 1'b0, 2'd0, 1'b1);
    chk("R9 dirty after write", 64'(lk_dirty), 64'd1);
    chk("R8 used after hit", 64'(lk_used), 64'd1);
    // R9: faulting write on entry 0 left dirty clear
    look(64'h0000_0000_0001_0000, 8'd5, 1'b0, 2'd0, 1'b1);
    chk("R9 faulting write not dirty", 64'(lk_dirty), 64'd0);
    chk("R8 used entry 0", 64'(lk_used), 64'd1);

    // R12 and R8 on a fresh entry
    wr(6, 52'h500, 52'h77, 8'd5, 1'b0, 3'd7, 3'd7, 1'b1, 5'd0);
    look(64'h0000_0000_0050_0010, 8'd5, 1'b0, 2'd1, 1'b0);
    chk("R12 disabled no hit", 64'(lk_hit), 64'd0);
    look(64'h0000_0000_0050_0010, 8'd5, 1'b0, 2'd0, 1'b1);
    chk("R12 hit enabled", 64'(lk_hit), 64'd1);
    chk("R12 used untouched", 64'(lk_used), 64'd0);
    chk("R12 dirty untouched", 64'(lk_dirty), 64'd0);
    chk("R4 pa fresh", lk_pa, 64'h77010);
    look(64'h0000_0000_0050_0010, 8'd5, 1'b0, 2'd0, 1'b1);
    chk("R8 used set by hit", 64'(lk_used), 64'd1);

    // R11: selective flush of ASID 5
    @(negedge clk);
    lk_valid = 1'b0; flush_asid = 8'd5; flush_asid_en = 1'b1;
    @(negedge clk);
    flush_asid_en = 1'b0;
    look(64'h0000_0000_0001_0234, 8'd5, 1'b0, 2'd0, 1'b1);
    chk("R11 asid entry removed", 64'(lk_hit), 64'd0);
    look(64'hFFFF_FFFF_1234_5678, 8'd5, 1'b0, 2'd0, 1'b1);
    chk("R11 global kept", lk_pa, 64'h0000_0001_1234_5678);
    look(64'h0000_0002_ABCD_E123, 8'd7, 1'b1, 2'd0, 1'b1);
    chk("R11 other asid kept", lk_pa, 64'h0000_0003_ABCD_E123);

    // R2: write wins over simultaneous flush
    @(negedge clk);
    lk_valid = 1'b0; flush_all = 1'b1;
    wr_en = 1'b1; wr_idx = IW'(0); wr_vpn = 52'h10; wr_ppn = 52'hABC; wr_asid = 8'd5;
    wr_global = 1'b0; wr_sup_rwx = 3'd7; wr_usr_rwx = 3'd7; wr_present = 1'b1; wr_size = 5'd0;
    @(negedge clk);
    wr_en = 1'b0; flush_all = 1'b0;
    look(64'h0000_0000_0001_0234, 8'd5, 1'b0, 2'd0, 1'b1);
    chk("R2 written entry survives flush", lk_pa, 64'h0000_0000_00AB_C234);
    chk("R2 used cleared on load", 64'(lk_used), 64'd0);
    look(64'h0000_0002_ABCD_E123, 8'd7, 1'b1, 2'd0, 1'b1);
    chk("R10 others flushed", 64'(lk_hit), 64'd0);

    // R10: full flush
    @(negedge clk);
    lk_valid = 1'b0; flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    look(64'h0000_0000_0001_0234, 8'd5, 1'b0, 2'd0, 1'b1);
    chk("R10 all flushed", 64'(lk_hit), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule